// File: doc/BRIEF.md
# DMA Mailbox with Request/Acknowledge Handshake

This block is a 16-byte mailbox that sits between the device and an external DMA controller. Its storage is split into two independent 8-byte FIFOs: a transmit half that the DMA controller fills from external memory, and a receive half that the DMA controller drains back to memory. The mailbox raises a transmit request while the transmit half has room and a receive request while the receive half holds data. The DMA controller answers either request with a shared acknowledge plus a strobe, and only such acknowledged strobes reach the storage. No host processor port exists.

A configuration input selects the strobe convention. With separate strobes, active-low read and write lines each mark a transfer. With the level-plus-strobe convention, a read/write level gives the direction and an active-low data strobe marks the transfer. Each transfer is taken once, on the clock where the strobe is first seen active. Inside the device, the protocol engines pop the transmit FIFO and push the receive FIFO through valid/ready ports.

A mode input enables the mailbox. While it is low, both requests are held low, the internal ports are closed and both FIFOs are flushed, so the storage can serve another purpose.

Top module: `dmaMailbox`

## Requirements
- R1: While `dmaMode` is 0, `txReq`, `rxReq`, `txOutValid` and `rxInReady` are all 0; after reset both FIFOs are empty.
- R2: `txReq` is 1 exactly when `dmaMode` is 1 and the transmit FIFO holds fewer than 8 bytes; it falls in the cycle after the 8th byte is written.
- R3: `rxReq` is 1 exactly when `dmaMode` is 1 and the receive FIFO holds at least one byte.
- R4: With `busMoto`=0, a clock edge that samples `wrN` low (having sampled it high on the previous edge) with `dmaAck`=1 and `txReq`=1 pushes `busDataIn` into the transmit FIFO; the same on `rdN` with `rxReq`=1 pops the receive FIFO head into `busDataOut`, which holds that byte until the next accepted read.
- R5: With `busMoto`=1, a newly sampled `dsN`=0 is a read when `rwLvl`=1 and a write when `rwLvl`=0, with the same acknowledge and request qualification as R4.
- R6: A strobe held active for several cycles transfers exactly one byte.
- R7: A strobe whose first active sample has `dmaAck`=0 transfers nothing.
- R8: A write while `txReq` is 0 and a read while `rxReq` is 0 are ignored; `busDataOut` keeps its value.
- R9: `txOutValid` is 1 while the transmit FIFO is non-empty in mailbox mode, `txOutData` shows its oldest byte, and a cycle with `txOutValid` and `txOutReady` high removes it; bytes leave in write order.
- R10: `rxInReady` is 1 while the receive FIFO has room in mailbox mode, and a cycle with `rxInValid` and `rxInReady` high stores `rxInData`; bytes are read out in push order.
- R11: Clearing `dmaMode` for a cycle empties both FIFOs: on re-enable `txReq`=1, `rxReq`=0, `txOutValid`=0.
- R12: With `busMoto`=0 the `dsN` and `rwLvl` lines have no effect; with `busMoto`=1 the `rdN` and `wrN` lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaMode | input | 1 | Mailbox enable; low flushes both halves |
| busMoto | input | 1 | 0: separate read/write strobes, 1: level plus data strobe |
| dmaAck | input | 1 | DMA acknowledge, qualifies strobes |
| rdN | input | 1 | Active-low read strobe (separate-strobe mode) |
| wrN | input | 1 | Active-low write strobe (separate-strobe mode) |
| rwLvl | input | 1 | Direction level, 1 read / 0 write (level mode) |
| dsN | input | 1 | Active-low data strobe (level mode) |
| busDataIn | input | 8 | Byte written by the DMA controller |
| busDataOut | output | 8 | Byte read by the DMA controller |
| txReq | output | 1 | Transmit request: transmit half has room |
| rxReq | output | 1 | Receive request: receive half holds data |
| txOutValid | output | 1 | Transmit byte available to the device |
| txOutReady | input | 1 | Device takes the transmit byte |
| txOutData | output | 8 | Oldest transmit byte |
| rxInValid | input | 1 | Device offers a receive byte |
| rxInReady | output | 1 | Receive half accepts a byte |
| rxInData | input | 8 | Receive byte from the device |

## Verification
On every cycle the assertions check that neither FIFO is pushed when full or popped when empty, that a flush leaves the FIFO empty, that the occupancy moves by at most one step, that no transfer happens without the acknowledge, that no two consecutive cycles carry a bus transfer of the same direction, and that the read data register only changes after an accepted read. Data ordering, the byte values returned, the strobe convention decode, the rejection of strobes on the inactive convention's lines and the request levels around full and empty are only shown by the bench's directed scenarios.

// File: rtl/dmaMbxPkg.sv
package dmaMbxPkg;
  localparam int DATA_W      = 8;
  localparam int TOTAL_BYTES = 16;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic flush;
  } mbxStrobe_t;
endpackage

// File: rtl/mbxFifo.sv
module mbxFifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] stepPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= stepPtr(wrPtr);
      if (pop)  rdPtr <= stepPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN) push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN) flush |=> empty); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flush) |-> (count == $past(count) || count == $past(count) + 1'b1 ||
                       count == $past(count) - 1'b1)); // R9
endmodule

// File: rtl/mbxCtrl.sv
module mbxCtrl
  import dmaMbxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaMode,
  input  logic       busMoto,
  input  logic       dmaAck,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       rwLvl,
  input  logic       dsN,
  input  logic       txFull,
  input  logic       rxEmpty,
  output logic       txReq,
  output logic       rxReq,
  output mbxStrobe_t strb
);
  logic rdActive, wrActive;
  logic rdPrev, wrPrev;
  logic rdEdge, wrEdge;

  // Strobe convention decode
  always_comb begin
    if (busMoto) begin
      rdActive = !dsN && rwLvl;
      wrActive = !dsN && !rwLvl;
    end else begin
      rdActive = !rdN;
      wrActive = !wrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdActive;
      wrPrev <= wrActive;
    end
  end

  assign rdEdge = rdActive && !rdPrev;
  assign wrEdge = wrActive && !wrPrev;

  assign txReq = dmaMode && !txFull;
  assign rxReq = dmaMode && !rxEmpty;

  always_comb begin
    strb.txPush = wrEdge && dmaAck && txReq;
    strb.rxPop  = rdEdge && dmaAck && rxReq;
    strb.flush  = !dmaMode;
  end

  AST_ONE_WRITE_PER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strb.txPush |=> !strb.txPush); // R6
  AST_ONE_READ_PER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxPop |=> !strb.rxPop); // R6
  AST_ACK_REQUIRED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txPush || strb.rxPop) |-> dmaAck); // R7
endmodule

// File: rtl/mbxDatapath.sv
module mbxDatapath
  import dmaMbxPkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  mbxStrobe_t    strb,
  input  logic [DW-1:0] busDataIn,
  output logic [DW-1:0] busDataOut,
  output logic          txFull,
  output logic          rxEmpty,
  output logic          txOutValid,
  input  logic          txOutReady,
  output logic [DW-1:0] txOutData,
  input  logic          rxInValid,
  output logic          rxInReady,
  input  logic [DW-1:0] rxInData
);
  logic txEmpty, rxFull;
  logic txPop, rxPush;
  logic [DW-1:0] rxHead;

  assign txOutValid = !txEmpty && !strb.flush;
  assign rxInReady  = !rxFull && !strb.flush;
  assign txPop      = txOutValid && txOutReady;
  assign rxPush     = rxInValid && rxInReady;

  mbxFifo #(.DEPTH(DEPTH), .WIDTH(DW)) txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(strb.txPush), .pushData(busDataIn),
    .pop(txPop), .headData(txOutData),
    .full(txFull), .empty(txEmpty)
  );

  mbxFifo #(.DEPTH(DEPTH), .WIDTH(DW)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.flush),
    .push(rxPush), .pushData(rxInData),
    .pop(strb.rxPop), .headData(rxHead),
    .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN)           busDataOut <= '0;
    else if (strb.rxPop) busDataOut <= rxHead;
  end

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.rxPop) |-> $stable(busDataOut)); // R8
endmodule

// File: rtl/dmaMailbox.sv
module dmaMailbox
  import dmaMbxPkg::*;
#(
  parameter int DW          = DATA_W,
  parameter int TOTAL_BYTES = dmaMbxPkg::TOTAL_BYTES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          dmaMode,
  input  logic          busMoto,
  input  logic          dmaAck,
  input  logic          rdN,
  input  logic          wrN,
  input  logic          rwLvl,
  input  logic          dsN,
  input  logic [DW-1:0] busDataIn,
  output logic [DW-1:0] busDataOut,
  output logic          txReq,
  output logic          rxReq,
  output logic          txOutValid,
  input  logic          txOutReady,
  output logic [DW-1:0] txOutData,
  input  logic          rxInValid,
  output logic          rxInReady,
  input  logic [DW-1:0] rxInData
);
  localparam int HALF_BYTES = TOTAL_BYTES / 2;

  mbxStrobe_t strb;
  logic txFull, rxEmpty;

  mbxCtrl ctrl (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .busMoto(busMoto),
    .dmaAck(dmaAck), .rdN(rdN), .wrN(wrN), .rwLvl(rwLvl), .dsN(dsN),
    .txFull(txFull), .rxEmpty(rxEmpty),
    .txReq(txReq), .rxReq(rxReq), .strb(strb)
  );

  mbxDatapath #(.DW(DW), .DEPTH(HALF_BYTES)) dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busDataIn(busDataIn), .busDataOut(busDataOut),
    .txFull(txFull), .rxEmpty(rxEmpty),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutData(txOutData),
    .rxInValid(rxInValid), .rxInReady(rxInReady), .rxInData(rxInData)
  );
endmodule

// File: tb/dmaMailbox_test.sv
module dmaMailbox_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, dmaMode, busMoto, dmaAck, rdN, wrN, rwLvl, dsN;
  logic [7:0] busDataIn, busDataOut, txOutData, rxInData;
  logic txReq, rxReq, txOutValid, txOutReady, rxInValid, rxInReady;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaMailbox uut (
    .clk(clk), .rstN(rstN), .dmaMode(dmaMode), .busMoto(busMoto),
    .dmaAck(dmaAck), .rdN(rdN), .wrN(wrN), .rwLvl(rwLvl), .dsN(dsN),
    .busDataIn(busDataIn), .busDataOut(busDataOut),
    .txReq(txReq), .rxReq(rxReq),
    .txOutValid(txOutValid), .txOutReady(txOutReady), .txOutData(txOutData),
    .rxInValid(rxInValid), .rxInReady(rxInReady), .rxInData(rxInData)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One bus transfer; pinsMoto picks which lines are wiggled.
  task automatic busXfer(input bit pinsMoto, input bit isWrite, input bit ack,
                         input logic [7:0] d, input int hold);
    @(negedge clk);
    busDataIn = d;
    dmaAck = ack;
    if (pinsMoto) begin rwLvl = !isWrite; dsN = 1'b0; end
    else if (isWrite) wrN = 1'b0;
    else rdN = 1'b0;
    repeat (hold) @(negedge clk);
    rdN = 1'b1; wrN = 1'b1; dsN = 1'b1; rwLvl = 1'b1; dmaAck = 1'b0;
    @(negedge clk);
  endtask

  task automatic popTx(input string tag, input logic [7:0] exp);
    @(negedge clk);
    check({tag, " txOutValid"}, txOutValid, 1);
    check({tag, " txOutData"}, txOutData, exp);
    txOutReady = 1'b1;
    @(negedge clk);
    txOutReady = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    @(negedge clk);
    rxInData = d;
    rxInValid = 1'b1;
    @(negedge clk);
    rxInValid = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0; dmaMode = 1'b0; busMoto = 1'b0; dmaAck = 1'b0;
    rdN = 1'b1; wrN = 1'b1; rwLvl = 1'b1; dsN = 1'b1; busDataIn = '0;
    txOutReady = 1'b0; rxInValid = 1'b0; rxInData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 txReq idle", txReq, 0);
    check("R1 rxReq idle", rxReq, 0);
    check("R1 txOutValid idle", txOutValid, 0);
    check("R1 rxInReady idle", rxInReady, 0);
    check("R1 busDataOut reset", busDataOut, 0);
    dmaMode = 1'b1;
    @(negedge clk);
    check("R2 txReq empty", txReq, 1);
    check("R3 rxReq empty", rxReq, 0);
    check("R10 rxInReady", rxInReady, 1);
  endtask

  task automatic tIntelWrite();
    busMoto = 1'b0;
    busXfer(0, 1, 1, 8'hA1, 1);
    busXfer(0, 1, 1, 8'hA2, 1);
    busXfer(0, 1, 1, 8'hA3, 1);
    popTx("R4 R9 first", 8'hA1);
    popTx("R4 R9 second", 8'hA2);
    popTx("R4 R9 third", 8'hA3);
    check("R9 drained", txOutValid, 0);
  endtask

  task automatic tTxFull();
    for (int i = 0; i < 8; i++) busXfer(0, 1, 1, 8'(8'h10 + i), 1);
    check("R2 txReq full", txReq, 0);
    busXfer(0, 1, 1, 8'hFF, 1);
    for (int i = 0; i < 8; i++) popTx("R8 full write ignored", 8'(8'h10 + i));
    check("R8 no extra byte", txOutValid, 0);
    check("R2 txReq after drain", txReq, 1);
  endtask

  task automatic tIntelRead();
    busMoto = 1'b0;
    pushRx(8'h51);
    pushRx(8'h52);
    check("R3 rxReq data", rxReq, 1);
    busXfer(0, 0, 1, 8'h00, 1);
    check("R4 read first", busDataOut, 8'h51);
    busXfer(0, 0, 1, 8'h00, 1);
    check("R10 read second", busDataOut, 8'h52);
    check("R3 rxReq empty", rxReq, 0);
    busXfer(0, 0, 1, 8'h00, 1);
    check("R8 empty read keeps bus", busDataOut, 8'h52);
  endtask

  task automatic tMoto();
    busMoto = 1'b1;
    busXfer(1, 1, 1, 8'hC3, 1);
    popTx("R5 moto write", 8'hC3);
    pushRx(8'h3C);
    busXfer(1, 0, 1, 8'h00, 1);
    check("R5 moto read", busDataOut, 8'h3C);
    check("R5 rxReq after read", rxReq, 0);
  endtask

  task automatic tNoAck();
    busMoto = 1'b0;
    busXfer(0, 1, 0, 8'h77, 1);
    check("R7 write no ack", txOutValid, 0);
    pushRx(8'h66);
    busXfer(0, 0, 0, 8'h00, 1);
    check("R7 read no ack bus", busDataOut, 8'h3C);
    check("R7 read no ack rxReq", rxReq, 1);
    busXfer(0, 0, 1, 8'h00, 1);
    check("R7 read with ack", busDataOut, 8'h66);
  endtask

  task automatic tHold();
    busMoto = 1'b0;
    busXfer(0, 1, 1, 8'h99, 4);
    popTx("R6 held strobe", 8'h99);
    check("R6 single byte", txOutValid, 0);
    busMoto = 1'b1;
    busXfer(1, 1, 1, 8'h9A, 3);
    popTx("R6 held moto strobe", 8'h9A);
    check("R6 single moto byte", txOutValid, 0);
  endtask

  task automatic tCross();
    busMoto = 1'b0;
    busXfer(1, 1, 1, 8'hE1, 1);
    check("R12 ds ignored in separate mode", txOutValid, 0);
    busMoto = 1'b1;
    busXfer(0, 1, 1, 8'hE2, 1);
    check("R12 wr ignored in level mode", txOutValid, 0);
    pushRx(8'hE3);
    busXfer(0, 0, 1, 8'h00, 1);
    check("R12 rd ignored in level mode", busDataOut, 8'h66);
    busXfer(1, 0, 1, 8'h00, 1);
    check("R12 level read works", busDataOut, 8'hE3);
  endtask

  task automatic tFlush();
    busMoto = 1'b0;
    busXfer(0, 1, 1, 8'h01, 1);
    busXfer(0, 1, 1, 8'h02, 1);
    pushRx(8'h03);
    @(negedge clk);
    dmaMode = 1'b0;
    @(negedge clk);
    check("R1 txReq off", txReq, 0);
    check("R1 rxReq off", rxReq, 0);
    check("R1 txOutValid off", txOutValid, 0);
    dmaMode = 1'b1;
    @(negedge clk);
    check("R11 txReq after flush", txReq, 1);
    check("R11 rxReq after flush", rxReq, 0);
    check("R11 txOutValid after flush", txOutValid, 0);
  endtask

  task automatic tRxFull();
    for (int i = 0; i < 8; i++) pushRx(8'(8'h80 + i));
    check("R10 rxInReady full", rxInReady, 0);
    pushRx(8'hFE);
    for (int i = 0; i < 8; i++) begin
      busXfer(0, 0, 1, 8'h00, 1);
      check("R10 rx order", busDataOut, 8'h80 + i);
    end
    check("R3 rxReq drained", rxReq, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tReset();
    tIntelWrite();
    tTxFull();
    tIntelRead();
    tMoto();
    tNoAck();
    tHold();
    tCross();
    tFlush();
    tRxFull();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule